// File: doc/BRIEF.md
# Per-Line Edge and Level Interrupt Detector

This block watches a bank of already conditioned input lines and records interrupt events in a per-line status vector. Out of reset every line reports any change of its level. Software can move any single line into an extended mode in which the line reports either an edge or a sustained level, with a polarity chosen per line. All configuration is done through write-one strobe vectors, where each bit of a vector acts on the line with the same index and a zero bit leaves that line alone.

The status vector is recorded for every line whether or not its interrupt is enabled. A separate enable vector, also written through set and clear strobes and readable on a port, decides which status bits reach the single combined interrupt output. Pulsing the read strobe for one cycle returns the status on the status port and empties it at the next clock edge. Software pulses it once before enabling interrupts to throw away stale events. An event that arrives in the same cycle as the read is kept.

Top module: `irq_det`

## Requirements
- R1: A line with extended mode off sets its status bit (bit i for line i) at the clock edge after its input differs from the value it had at the previous edge.
- R2: Bit i of `altSet` turns extended mode on for line i and bit i of `altClr` turns it off; if both are set in the same cycle the line ends up with extended mode off. Extended mode is off after reset.
- R3: In extended mode with edge detection chosen, a line flags a 0-to-1 step when its polarity is rising/high and a 1-to-0 step when its polarity is falling/low. A bit in `edgeSel` chooses edge detection and a bit in `levelSel` chooses level detection; `edgeSel` wins if both are set. A bit in `riseHighSel` chooses rising/high and a bit in `fallLowSel` chooses falling/low; `riseHighSel` wins if both are set. After reset, level detection and falling/low polarity are chosen.
- R4: In extended mode with level detection chosen, a line flags every edge at which its input equals the active level (1 for rising/high, 0 for falling/low).
- R5: Bit i of `intEnSet` enables line i and bit i of `intEnClr` disables it, with disable winning when both are set; `maskOut` shows the enable vector one edge after the strobe. All lines are disabled after reset.
- R6: A one-cycle `statusRd` pulse clears every status bit at the next edge; without a read, a set status bit stays set.
- R7: A level-mode line whose active level is still present sets its status bit again at the edge that clears it on a read, and on every following edge.
- R8: `irq` is 1 exactly when some line has both its status bit and its enable bit set.
- R9: An event detected at the same edge as a status read is recorded and not lost.
- R10: Status bits are recorded for disabled lines; the enable vector only gates `irq`.
- R11: Reset clears status, enables and configuration; no event is flagged at the first edge after reset release, so input values held during reset cause no spurious change event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | LINES | Conditioned input levels, bit i is line i |
| intEnSet | input | LINES | Write-one strobes that enable line interrupts |
| intEnClr | input | LINES | Write-one strobes that disable line interrupts |
| altSet | input | LINES | Write-one strobes that turn on extended mode |
| altClr | input | LINES | Write-one strobes that turn off extended mode |
| edgeSel | input | LINES | Write-one strobes that choose edge detection |
| levelSel | input | LINES | Write-one strobes that choose level detection |
| riseHighSel | input | LINES | Write-one strobes that choose rising/high polarity |
| fallLowSel | input | LINES | Write-one strobes that choose falling/low polarity |
| statusRd | input | 1 | Status read strobe, clears status at the next edge |
| statusOut | output | LINES | Current status vector |
| maskOut | output | LINES | Current interrupt enable vector |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench gives each group of four lines one of the eight mode and polarity combinations and each line inside the group one of the four before/after input pairs. The 32 lines therefore cover every mode against every transition at once, and the assignment of combinations to groups is rotated. The transition is applied in the same cycle as a status read, so a design that lets the read override a new event (R9) would come back with an empty vector. The cycles after it check that level-mode lines re-arm after a read while edge and change lines stay quiet. A design that filtered status through the enable vector, or let set beat clear on a shared strobe cycle, would show different bits on `statusOut` or `maskOut` than the arithmetic expectation. Holding the inputs high through reset catches a design that reports a change at the first edge after reset.

// File: rtl/irq_det_pkg.sv
package irq_det_pkg;
  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic armed;     // event capture allowed (not the first edge after reset)
    logic clearReq;  // status read in progress this cycle
  } detCtrl_t;
endpackage

// File: rtl/irq_det_cfg.sv
module irq_det_cfg
  import irq_det_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] intEnSet,
  input  logic [LINES-1:0] intEnClr,
  input  logic [LINES-1:0] altSet,
  input  logic [LINES-1:0] altClr,
  input  logic [LINES-1:0] edgeSel,
  input  logic [LINES-1:0] levelSel,
  input  logic [LINES-1:0] riseHighSel,
  input  logic [LINES-1:0] fallLowSel,
  input  logic             statusRd,
  output logic [LINES-1:0] maskQ,
  output logic [LINES-1:0] altQ,
  output logic [LINES-1:0] edgeQ,
  output logic [LINES-1:0] polQ,
  output detCtrl_t         ctrl
);
  logic armedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= '0;
      altQ   <= '0;
      edgeQ  <= '0;
      polQ   <= '0;
      armedQ <= 1'b0;
    end else begin
      // Enable and extended mode: clear has priority.
      maskQ  <= (maskQ | intEnSet) & ~intEnClr;
      altQ   <= (altQ | altSet) & ~altClr;
      // Detection kind and polarity: the edge / rising-high strobe has priority.
      edgeQ  <= (edgeQ & ~levelSel) | edgeSel;
      polQ   <= (polQ & ~fallLowSel) | riseHighSel;
      armedQ <= 1'b1;
    end
  end

  always_comb begin
    ctrl.armed    = armedQ;
    ctrl.clearReq = statusRd;
  end
endmodule

// File: rtl/irq_det_path.sv
module irq_det_path
  import irq_det_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] lineIn,
  input  logic [LINES-1:0] maskQ,
  input  logic [LINES-1:0] altQ,
  input  logic [LINES-1:0] edgeQ,
  input  logic [LINES-1:0] polQ,
  input  detCtrl_t         ctrl,
  output logic [LINES-1:0] prevQ,
  output logic [LINES-1:0] statusQ,
  output logic             irqOut
);
  logic [LINES-1:0] hit;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic riseHit;
    logic fallHit;
    logic levelHit;
    assign riseHit  = lineIn[i] & ~prevQ[i];
    assign fallHit  = ~lineIn[i] & prevQ[i];
    assign levelHit = (lineIn[i] == polQ[i]);
    assign hit[i] = !altQ[i] ? (riseHit | fallHit)
                  : edgeQ[i] ? (polQ[i] ? riseHit : fallHit)
                  : levelHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ   <= '0;
      statusQ <= '0;
    end else begin
      prevQ   <= lineIn;
      statusQ <= (ctrl.clearReq ? '0 : statusQ) | (ctrl.armed ? hit : '0);
    end
  end

  assign irqOut = |(statusQ & maskQ);
endmodule

// File: rtl/irq_det.sv
module irq_det
  import irq_det_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] lineIn,
  input  logic [LINES-1:0] intEnSet,
  input  logic [LINES-1:0] intEnClr,
  input  logic [LINES-1:0] altSet,
  input  logic [LINES-1:0] altClr,
  input  logic [LINES-1:0] edgeSel,
  input  logic [LINES-1:0] levelSel,
  input  logic [LINES-1:0] riseHighSel,
  input  logic [LINES-1:0] fallLowSel,
  input  logic             statusRd,
  output logic [LINES-1:0] statusOut,
  output logic [LINES-1:0] maskOut,
  output logic             irq
);
  logic [LINES-1:0] maskQ;
  logic [LINES-1:0] altQ;
  logic [LINES-1:0] edgeQ;
  logic [LINES-1:0] polQ;
  logic [LINES-1:0] prevQ;
  logic [LINES-1:0] statusQ;
  detCtrl_t         ctrl;

  irq_det_cfg #(.LINES(LINES)) u_cfg (
    .clk(clk), .rstN(rstN),
    .intEnSet(intEnSet), .intEnClr(intEnClr),
    .altSet(altSet), .altClr(altClr),
    .edgeSel(edgeSel), .levelSel(levelSel),
    .riseHighSel(riseHighSel), .fallLowSel(fallLowSel),
    .statusRd(statusRd),
    .maskQ(maskQ), .altQ(altQ), .edgeQ(edgeQ), .polQ(polQ),
    .ctrl(ctrl)
  );

  irq_det_path #(.LINES(LINES)) u_path (
    .clk(clk), .rstN(rstN),
    .lineIn(lineIn),
    .maskQ(maskQ), .altQ(altQ), .edgeQ(edgeQ), .polQ(polQ),
    .ctrl(ctrl),
    .prevQ(prevQ), .statusQ(statusQ), .irqOut(irq)
  );

  assign statusOut = statusQ;
  assign maskOut   = maskQ;
endmodule

// File: rtl/irq_det_chk.sv
module irq_det_chk #(
  parameter int LINES = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [LINES-1:0] lineIn,
  input logic [LINES-1:0] intEnSet,
  input logic [LINES-1:0] intEnClr,
  input logic             statusRd,
  input logic [LINES-1:0] statusOut,
  input logic [LINES-1:0] maskOut,
  input logic             irq,
  input logic [LINES-1:0] altQ,
  input logic [LINES-1:0] edgeQ,
  input logic [LINES-1:0] polQ,
  input logic [LINES-1:0] prevQ,
  input logic             armed
);
  // R5: strobes take effect at the next edge, disable wins.
  assert_mask_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((maskOut & $past(intEnSet & ~intEnClr)) == $past(intEnSet & ~intEnClr))
              && ((maskOut & $past(intEnClr)) == '0)));

  // R6: without a read no status bit drops.
  assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    !statusRd |=> (($past(statusOut) & ~statusOut) == '0));

  // R8: the interrupt output needs at least one status bit.
  assert_irq_needs_status_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusOut != '0));

  // R1 and R9: any change on a default-mode line lands in status, read or not.
  assert_change_recorded_R1: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> ((statusOut & $past(~altQ & (lineIn ^ prevQ))) == $past(~altQ & (lineIn ^ prevQ))));

  // R7: an active level-mode line is present in status after every edge.
  assert_level_rearm_R7: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> ((statusOut & $past(altQ & ~edgeQ & ~(lineIn ^ polQ)))
               == $past(altQ & ~edgeQ & ~(lineIn ^ polQ))));
endmodule

bind irq_det irq_det_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rstN(rstN), .lineIn(lineIn),
  .intEnSet(intEnSet), .intEnClr(intEnClr),
  .statusRd(statusRd), .statusOut(statusOut), .maskOut(maskOut), .irq(irq),
  .altQ(altQ), .edgeQ(edgeQ), .polQ(polQ), .prevQ(prevQ), .armed(ctrl.armed)
);

// File: tb/test_irq_det.sv
module test_irq_det;
  localparam int LINES = 32;

  logic             clk;
  logic             rstN;
  logic [LINES-1:0] lineIn, intEnSet, intEnClr, altSet, altClr;
  logic [LINES-1:0] edgeSel, levelSel, riseHighSel, fallLowSel;
  logic             statusRd;
  logic [LINES-1:0] statusOut, maskOut;
  logic             irq;

  int nChecks = 0;
  int nFails  = 0;

  irq_det #(.LINES(LINES)) i_irq_det (
    .clk(clk), .rstN(rstN), .lineIn(lineIn),
    .intEnSet(intEnSet), .intEnClr(intEnClr),
    .altSet(altSet), .altClr(altClr),
    .edgeSel(edgeSel), .levelSel(levelSel),
    .riseHighSel(riseHighSel), .fallLowSel(fallLowSel),
    .statusRd(statusRd),
    .statusOut(statusOut), .maskOut(maskOut), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [LINES-1:0] act, input logic [LINES-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearStrobes();
    intEnSet = '0; intEnClr = '0; altSet = '0; altClr = '0;
    edgeSel = '0; levelSel = '0; riseHighSel = '0; fallLowSel = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [LINES-1:0] prevV, curV, defL, edgeL, levL, expV, levAct;
    rstN = 1'b0; statusRd = 1'b0; lineIn = '1;
    clearStrobes();
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R11: reset state and no change event from inputs held during reset
    chk("R11 status", statusOut, '0);
    chk("R11 mask", maskOut, '0);
    chk("R11 irq", {31'd0, irq}, '0);
    step();
    chk("R11 first edge", statusOut, '0);

    // R5: set/clear strobes, clear wins on a shared cycle
    intEnSet = 32'hF0F0_00FF; step(); intEnSet = '0;
    chk("R5 set", maskOut, 32'hF0F0_00FF);
    intEnSet = 32'h0000_FF00; intEnClr = 32'h0000_0F0F; step(); clearStrobes();
    chk("R5 set+clr", maskOut, 32'hF0F0_F0F0);
    intEnClr = '1; step(); clearStrobes();
    chk("R5 clear all", maskOut, '0);

    for (int rot = 0; rot < 4; rot++) begin
      prevV = '0; curV = '0; defL = '0; edgeL = '0; levL = '0; expV = '0; levAct = '0;
      clearStrobes();
      for (int i = 0; i < LINES; i++) begin
        int m;
        logic a, e, p, pv, cu;
        m  = ((i >> 2) + rot) & 7;
        a  = m[2]; e = m[1]; p = m[0];
        pv = i[1]; cu = i[0];
        prevV[i] = pv; curV[i] = cu;
        if (a) altSet[i] = 1'b1; else altClr[i] = 1'b1;
        if (e) edgeSel[i] = 1'b1; else levelSel[i] = 1'b1;
        if (p) riseHighSel[i] = 1'b1; else fallLowSel[i] = 1'b1;
        if (!a) begin
          defL[i] = 1'b1; expV[i] = pv ^ cu;
        end else if (e) begin
          edgeL[i] = 1'b1; expV[i] = p ? (!pv && cu) : (pv && !cu);
        end else begin
          levL[i] = 1'b1; expV[i] = (cu == p); levAct[i] = (cu == p);
        end
      end
      // Extra same-cycle strobes to check priority: edge beats level, rise beats fall.
      levelSel = levelSel | edgeSel;
      fallLowSel = fallLowSel | riseHighSel;
      lineIn = prevV;
      step(); clearStrobes();
      step(); step();
      // Transition and status read in the same cycle.
      lineIn = curV; statusRd = 1'b1;
      step(); statusRd = 1'b0;
      chk("R1 change lines", statusOut & defL, expV & defL);
      chk("R3 edge lines", statusOut & edgeL, expV & edgeL);
      chk("R4 level lines", statusOut & levL, expV & levL);
      chk("R9 event with read", statusOut, expV);
      step();
      statusRd = 1'b1; step(); statusRd = 1'b0;
      chk("R7 level rearm on read", statusOut, levAct);
      step();
      chk("R7 level held", statusOut, levAct);
      // R10: status kept for disabled lines, irq off with disjoint enables
      intEnSet = ~levAct; step(); clearStrobes();
      chk("R10 status masked", statusOut, levAct);
      chk("R8 irq low", {31'd0, irq}, '0);
      intEnSet = levAct & (~levAct + 1'b1); step(); clearStrobes();
      chk("R8 irq high", {31'd0, irq}, 32'd1);
      intEnClr = '1; step(); clearStrobes();
      chk("R8 irq after disable", {31'd0, irq}, '0);
    end

    // R2: extended mode off everywhere (set and clear together, clear wins)
    altSet = '1; altClr = '1; lineIn = 32'h0F0F_3C3C;
    step(); clearStrobes();
    statusRd = 1'b1; step(); statusRd = 1'b0;
    step();
    chk("R6 stable after read", statusOut, '0);
    lineIn = 32'hF0F0_3CC3; step();
    chk("R2 default mode restored", statusOut, 32'hFFFF_00FF);
    step();
    chk("R6 sticky without read", statusOut, 32'hFFFF_00FF);
    statusRd = 1'b1; step(); statusRd = 1'b0;
    chk("R6 read clears", statusOut, '0);
    chk("R8 irq idle", {31'd0, irq}, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule